// File: doc/BRIEF.md
# Stepped-Sweep Sine Synthesizer

This block produces a digitally synthesized sine wave whose frequency moves through a programmed range in equal steps. A 24-bit phase accumulator adds a tuning word on every clock. Its ten most significant bits index a 1024-entry sine table, and the table's 10-bit offset-binary code drives an external converter. At a 40 MHz clock the frequency resolution is about 2.38 Hz per tuning-word unit. A 100 kHz tone still gets more than 32 table samples per period.

A sequencer supplies the tuning word. The host gives it three tuning words (first, last and increment) and a dwell length in clocks, then pulses a start input. Each point is held for the dwell length so that a downstream measurement can settle and sample. At the end of each dwell the block raises a one-clock ready strobe. The next point is then taken either at once (automatic mode) or on the next rising edge of a manual advance input. When the next word would pass the last word, the sweep stops and holds its final frequency.

Top module: `sweep_dds`

## Requirements
- R1: While reset is held and after it is released, with no start pulse yet, `sample_o` is 512, `freq_word_o` is 0, and `point_valid_o` and `done_o` are 0.
- R2: The phase advances by `freq_word_o` on every clock. A start pulse clears the phase to 0. `sample_o` is the table code for phase bits [23:14], delayed one clock by a register. The code is round(511.5 + 511.5·sin(2π·i/1024)), so index 0 gives 512, 256 gives 1023, 512 gives 512 and 768 gives 0.
- R3: A start pulse, accepted in any state (including mid-sweep), loads `start_word_i` onto `freq_word_o` at that clock edge, clears `done_o` and begins a new dwell.
- R4: `point_valid_o` is high for exactly one clock. It rises D clock edges after the edge that made the current word take effect, where D is `dwell_i`, and a `dwell_i` of 0 behaves as 1.
- R5: In automatic mode (`auto_i` = 1), each point's word is the previous word plus `step_word_i`, and successive strobes are D+1 clocks apart.
- R6: If the current word plus the step (computed with a carry bit, so that passing 2^24 counts as exceeding) is greater than `stop_word_i`, no advance happens. `done_o` rises one clock after the last strobe, and the word then stays fixed with no further strobes. The sweep visits floor((stop−start)/step)+1 points, and exactly one point when stop < start.
- R7: In manual mode (`auto_i` = 0), after a strobe the word advances once per rising edge of `step_i`. Holding `step_i` high gives only one advance.
- R8: In manual mode, rising edges of `step_i` that occur during a dwell are discarded and do not advance the sweep afterwards.
- R9: `freq_word_o` does not change during a dwell unless a start pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-clock pulse that (re)starts the sweep |
| auto_i | input | 1 | 1 = automatic stepping, 0 = manual stepping |
| step_i | input | 1 | Manual advance; acts on rising edge |
| start_word_i | input | 24 | First tuning word |
| stop_word_i | input | 24 | Highest tuning word allowed |
| step_word_i | input | 24 | Tuning-word increment per point |
| dwell_i | input | 16 | Dwell length in clocks (0 treated as 1) |
| sample_o | output | 10 | Offset-binary sine sample for the converter |
| freq_word_o | output | 24 | Tuning word currently in use |
| point_valid_o | output | 1 | One-clock strobe at the end of each dwell |
| done_o | output | 1 | Sweep finished; frequency held |

## Verification
The hardest situations to reach are at the end of the range. One is the advance whose sum carries past 24 bits and must stop the sweep instead of wrapping back to a low frequency. The other is a stop word that lies below the start word. The stimulus table places a start word just under full scale with a step that overflows on the second point, and includes a reversed range. Another case that is hard to reach is a manual edge that lands inside a dwell. Directed tests toggle the advance input in the middle of a long dwell, then confirm through the strobe count and the word output that no advance was stored.

// File: rtl/sweep_dds_pkg.sv
`timescale 1ns/1ps
package sweep_dds_pkg;

  typedef enum logic [1:0] {
    SW_IDLE  = 2'd0,
    SW_DWELL = 2'd1,
    SW_ADV   = 2'd2,
    SW_DONE  = 2'd3
  } sweep_state_e;

  // Offset-binary sine code for table index idx of depth entries.
  function automatic int sine_code(int idx, int depth, int width);
    real amp;
    real ang;
    amp = ((2.0 ** width) - 1.0) / 2.0;
    ang = 2.0 * 3.14159265358979 * real'(idx) / real'(depth);
    return $rtoi(amp + amp * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/sweep_dds_acc.sv
`timescale 1ns/1ps
module sweep_dds_acc #(
  parameter int ACC_W  = 24,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic [ACC_W-1:0]  word_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    if (clr_i) acc_d = '0;
    else       acc_d = acc_q + word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign addr_o = acc_q[ACC_W-1 -: ADDR_W];

  AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (addr_o == '0)); // R2

endmodule

// File: rtl/sweep_dds_rom.sv
`timescale 1ns/1ps
module sweep_dds_rom #(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SAMP_W-1:0] sample_o
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SAMP_W-1:0] MID_CODE = SAMP_W'(1) << (SAMP_W - 1);

  logic [SAMP_W-1:0] table_w [DEPTH];
  logic [SAMP_W-1:0] sample_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
    assign table_w[gi] = SAMP_W'(sweep_dds_pkg::sine_code(gi, DEPTH, SAMP_W));
  end

  assign sample_d = table_w[addr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_o <= MID_CODE;
    else        sample_o <= sample_d;
  end

  AST_ZERO_PHASE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == '0) |=> (sample_o == MID_CODE)); // R2

endmodule

// File: rtl/sweep_dds_seq.sv
`timescale 1ns/1ps
module sweep_dds_seq
  import sweep_dds_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               auto_i,
  input  logic               step_i,
  input  logic [ACC_W-1:0]   start_word_i,
  input  logic [ACC_W-1:0]   stop_word_i,
  input  logic [ACC_W-1:0]   step_word_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic [ACC_W-1:0]   word_o,
  output logic               point_valid_o,
  output logic               done_o
);

  sweep_state_e       state_q, state_d;
  logic [ACC_W-1:0]   word_q, word_d;
  logic               word_en;
  logic [DWELL_W-1:0] cnt_q, cnt_d;
  logic               pv_q, pv_d;
  logic               step_q;
  logic               step_edge;
  logic [ACC_W:0]     sum_w;
  logic               past_stop;
  logic [DWELL_W-1:0] dwell_last;

  assign step_edge  = step_i & ~step_q;
  assign sum_w      = {1'b0, word_q} + {1'b0, step_word_i};
  assign past_stop  = sum_w > {1'b0, stop_word_i};
  assign dwell_last = (dwell_i == '0) ? '0 : dwell_i - 1'b1;

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    word_en = 1'b0;
    cnt_d   = cnt_q;
    pv_d    = 1'b0;
    if (start_i) begin
      state_d = SW_DWELL;
      word_d  = start_word_i;
      word_en = 1'b1;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        SW_DWELL: begin
          if (cnt_q == dwell_last) begin
            pv_d    = 1'b1;
            state_d = SW_ADV;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SW_ADV: begin
          if (auto_i || step_edge) begin
            if (past_stop) begin
              state_d = SW_DONE;
            end else begin
              word_d  = sum_w[ACC_W-1:0];
              word_en = 1'b1;
              state_d = SW_DWELL;
              cnt_d   = '0;
            end
          end
        end
        SW_IDLE, SW_DONE: begin
          state_d = state_q;
        end
        default: state_d = SW_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      cnt_q   <= '0;
      pv_q    <= 1'b0;
      step_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pv_q    <= pv_d;
      step_q  <= step_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= '0;
    else if (word_en) word_q <= word_d;
  end

  assign word_o        = word_q;
  assign point_valid_o = pv_q;
  assign done_o        = (state_q == SW_DONE);

  AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |=> !pv_q); // R4
  AST_DWELL_WORD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_DWELL && !start_i) |=> $stable(word_q)); // R9
  AST_DONE_FREEZES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_DONE && !start_i) |=> $stable(word_q)); // R6
  AST_DONE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !pv_q); // R6
  AST_MANUAL_WAITS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SW_ADV && !auto_i && !start_i && !(step_i && !step_q))
      |=> $stable(word_q)); // R7

endmodule

// File: rtl/sweep_dds.sv
`timescale 1ns/1ps
module sweep_dds #(
  parameter int ACC_W   = 24,
  parameter int ADDR_W  = 10,
  parameter int SAMP_W  = 10,
  parameter int DWELL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               auto_i,
  input  logic               step_i,
  input  logic [ACC_W-1:0]   start_word_i,
  input  logic [ACC_W-1:0]   stop_word_i,
  input  logic [ACC_W-1:0]   step_word_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic [SAMP_W-1:0]  sample_o,
  output logic [ACC_W-1:0]   freq_word_o,
  output logic               point_valid_o,
  output logic               done_o
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [ADDR_W-1:0] phase_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  sweep_dds_seq #(
    .ACC_W   (ACC_W),
    .DWELL_W (DWELL_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .start_i       (start_i),
    .auto_i        (auto_i),
    .step_i        (step_i),
    .start_word_i  (start_word_i),
    .stop_word_i   (stop_word_i),
    .step_word_i   (step_word_i),
    .dwell_i       (dwell_i),
    .word_o        (freq_word_o),
    .point_valid_o (point_valid_o),
    .done_o        (done_o)
  );

  sweep_dds_acc #(
    .ACC_W  (ACC_W),
    .ADDR_W (ADDR_W)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (start_i),
    .word_i (freq_word_o),
    .addr_o (phase_addr)
  );

  sweep_dds_rom #(
    .ADDR_W (ADDR_W),
    .SAMP_W (SAMP_W)
  ) u_rom (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_i   (phase_addr),
    .sample_o (sample_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> (!done_o && !point_valid_o)); // R1

endmodule

// File: tb/sweep_dds_test.sv
`timescale 1ns/1ps
module sweep_dds_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic        auto_i;
  logic        step_i;
  logic [23:0] start_word_i;
  logic [23:0] stop_word_i;
  logic [23:0] step_word_i;
  logic [15:0] dwell_i;
  logic [9:0]  sample_o;
  logic [23:0] freq_word_o;
  logic        point_valid_o;
  logic        done_o;

  int checks;
  int failures;
  bit finished;

  sweep_dds uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .auto_i        (auto_i),
    .step_i        (step_i),
    .start_word_i  (start_word_i),
    .stop_word_i   (stop_word_i),
    .step_word_i   (step_word_i),
    .dwell_i       (dwell_i),
    .sample_o      (sample_o),
    .freq_word_o   (freq_word_o),
    .point_valid_o (point_valid_o),
    .done_o        (done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {start, stop, step, dwell, expected points, expected final word}
  localparam int NVEC = 5;
  localparam logic [119:0] VEC [NVEC] = '{
    {24'd1000,     24'd1100,     24'd25,   16'd4, 8'd5, 24'd1000 + 24'd100},
    {24'd42,       24'd42,       24'd7,    16'd0, 8'd1, 24'd42},
    {24'hFFFF00,   24'hFFFFFF,   24'h80,   16'd2, 8'd2, 24'hFFFF80},
    {24'd100,      24'd130,      24'd10,   16'd1, 8'd4, 24'd130},
    {24'd5,        24'd4,        24'd1,    16'd3, 8'd1, 24'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    checks = 0; failures = 0; finished = 1'b0;
    rst_n = 1'b0; start_i = 1'b0; auto_i = 1'b1; step_i = 1'b0;
    start_word_i = '0; stop_word_i = '0; step_word_i = '0; dwell_i = '0;
    repeat (4) @(negedge clk);
    chk("R1 sample in reset", 32'(sample_o), 512);
    chk("R1 word in reset", 32'(freq_word_o), 0);
    chk("R1 strobe in reset", 32'(point_valid_o), 0);
    chk("R1 done in reset", 32'(done_o), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1 sample after release", 32'(sample_o), 512);
    chk("R1 word after release", 32'(freq_word_o), 0);
    chk("R1 done after release", 32'(done_o), 0);

    // Stimulus table, automatic mode
    for (int v = 0; v < NVEC; v++) begin
      logic [23:0] s_w, e_w, st_w, fin_w, exp_w;
      logic [15:0] dw;
      logic [7:0]  npts;
      int deff, n, k, last, extra;
      {s_w, e_w, st_w, dw, npts, fin_w} = VEC[v];
      deff = (dw == 0) ? 1 : int'(dw);
      @(negedge clk);
      auto_i = 1'b1; start_word_i = s_w; stop_word_i = e_w;
      step_word_i = st_w; dwell_i = dw;
      pulse_start();
      chk("R3 done cleared on start", 32'(done_o), 0);
      chk("R3 start word loaded", 32'(freq_word_o), 32'(s_w));
      n = 0; k = 0; last = 0; exp_w = s_w;
      while (!done_o && n < 3000) begin
        @(negedge clk);
        n++;
        if (point_valid_o) begin
          chk("R5 point word", 32'(freq_word_o), 32'(exp_w));
          if (k == 0) chk("R4 first strobe delay", 32'(n), 32'(deff));
          else        chk("R5 strobe spacing", 32'(n - last), 32'(deff + 1));
          last = n; k++; exp_w = exp_w + st_w;
        end
      end
      chk("R6 done one clock after last strobe", 32'(n), 32'(last + 1));
      chk("R6 point count", 32'(k), 32'(npts));
      chk("R6 final word", 32'(freq_word_o), 32'(fin_w));
      extra = 0;
      repeat (12) begin
        @(negedge clk);
        if (point_valid_o) extra++;
      end
      chk("R6 no strobe after done", 32'(extra), 0);
      chk("R6 word held after done", 32'(freq_word_o), 32'(fin_w));
      chk("R6 done stays high", 32'(done_o), 1);
    end

    // R2: sample sequence for a quarter-cycle-per-clock word
    @(negedge clk);
    auto_i = 1'b1; start_word_i = 24'h400000; stop_word_i = 24'h400000;
    step_word_i = 24'd1; dwell_i = 16'd100;
    pulse_start();
    @(negedge clk); chk("R2 sample phase 0", 32'(sample_o), 512);
    @(negedge clk); chk("R2 sample phase 256", 32'(sample_o), 1023);
    @(negedge clk); chk("R2 sample phase 512", 32'(sample_o), 512);
    @(negedge clk); chk("R2 sample phase 768", 32'(sample_o), 0);
    @(negedge clk); chk("R2 sample wraps to 0", 32'(sample_o), 512);

    // R3: restart in the middle of a dwell
    begin
      int n;
      @(negedge clk);
      start_word_i = 24'd1000; stop_word_i = 24'd5000;
      step_word_i = 24'd10; dwell_i = 16'd40;
      pulse_start();
      repeat (20) @(negedge clk);
      start_word_i = 24'd3000;
      pulse_start();
      chk("R3 restart loads new word", 32'(freq_word_o), 3000);
      n = 0;
      while (!point_valid_o && n < 200) begin
        @(negedge clk);
        n++;
      end
      chk("R3 restart dwell length", 32'(n), 40);
      chk("R3 restart point word", 32'(freq_word_o), 3000);
    end

    // R7: manual mode, held advance input gives one step
    begin
      int pv;
      @(negedge clk);
      auto_i = 1'b0; step_i = 1'b0; start_word_i = 24'd200;
      stop_word_i = 24'd900; step_word_i = 24'd50; dwell_i = 16'd6;
      pulse_start();
      while (!point_valid_o) @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R7 manual waits for edge", 32'(freq_word_o), 200);
      step_i = 1'b1;
      pv = 0;
      repeat (40) begin
        @(negedge clk);
        if (point_valid_o) pv++;
      end
      chk("R7 held input advances once", 32'(freq_word_o), 250);
      chk("R7 one strobe after advance", 32'(pv), 1);
      step_i = 1'b0;
      @(negedge clk);
      step_i = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 new edge advances again", 32'(freq_word_o), 300);
      step_i = 1'b0;
    end

    // R8: edge inside a dwell is discarded
    begin
      int pv;
      @(negedge clk);
      dwell_i = 16'd30;
      pulse_start();
      repeat (5) @(negedge clk);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      pv = 0;
      repeat (50) begin
        @(negedge clk);
        if (point_valid_o) pv++;
      end
      chk("R8 dwell edge ignored word", 32'(freq_word_o), 200);
      chk("R8 single strobe only", 32'(pv), 1);
      chk("R8 not done", 32'(done_o), 0);
    end

    finish_run();
  end

endmodule